// File: doc/BRIEF.md
# Polled Keypad and Millisecond Timer Peripheral

This block sits on the processor's data bus and offers two read-only registers that software polls. One returns the pressed/released state of eight keys. The raw key lines are first brought into the clock domain and then filtered against contact bounce. The other returns a free-running count of milliseconds since reset. A prescaler divides the system clock into a one-cycle tick each millisecond, and that tick advances the count.

A read request is decoded against two fixed word addresses. The selected value comes back on the read data lines in the same cycle, with no wait state. Any other address returns zero. Writes are accepted on the bus but change nothing. There is no interrupt path: software learns of key changes and elapsed time only by reading.

Top module: `kpt_io_periph`

## Requirements
- R1: A read at address 0xFFFF0004 returns the filtered key state in rd_data[7:0] and zeros in every higher bit. Bit k is 1 while key k is held and 0 while it is released.
- R2: A read at address 0xFFFF0008 returns the millisecond count, zero-extended to the data width.
- R3: Each key line passes through a two-flop synchronizer. The filtered bit takes the synchronized value only after that value has differed from it for DEBOUNCE_MS*CLK_HZ/1000 consecutive cycles, so a shorter pulse leaves the bit unchanged.
- R4: The count advances by exactly one every CLK_HZ/1000 clock cycles, and by one per tick at most.
- R5: The count is TMR_W bits wide (32 by default) and wraps from all ones to zero.
- R6: A synchronous reset, active high, clears the count, the prescaler, the synchronizers and the filtered key state.
- R7: A read whose address does not equal one of the two register addresses exactly, byte offset included, returns zero. rd_data is also zero whenever rd_en is low.
- R8: A write to either register address leaves both the key state and the count unchanged.
- R9: rd_data is valid combinationally, in the same cycle as the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_addr_i | input | 32 | Byte address of the bus access |
| bus_rd_en_i | input | 1 | Read request |
| bus_wr_en_i | input | 1 | Write request (ignored) |
| bus_wr_data_i | input | 32 | Write data (ignored) |
| bus_rd_data_o | output | 32 | Read data, valid in the request cycle |
| keys_raw_i | input | 8 | Asynchronous key lines, 1 = pressed |

## Verification
The bench builds the block with CLK_HZ = 8000, DEBOUNCE_MS = 2 and TMR_W = 8. With these values a millisecond is 8 cycles and the filter window is 16 cycles, so both the tick spacing and the glitch rejection show within a few dozen cycles. The narrow count wraps after 2048 cycles, which brings the rollover of R5 within a short run. A behavioural model tracks the key runs and the elapsed cycles and is compared with the read data on every clock, across key presses, short glitches, stray addresses, writes and a reset in mid-run.

// File: rtl/kpt_pkg.sv
package kpt_pkg;

    localparam int unsigned KPT_ADDR_W = 32;
    localparam int unsigned KPT_DATA_W = 32;

    localparam logic [KPT_ADDR_W-1:0] KPT_KEY_ADDR = 32'hFFFF_0004;
    localparam logic [KPT_ADDR_W-1:0] KPT_TMR_ADDR = 32'hFFFF_0008;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_KEYS  = 2'd1,
        SEL_TIMER = 2'd2
    } kpt_sel_e;

endpackage

// File: rtl/kpt_key_filter.sv
module kpt_key_filter #(
    parameter int unsigned DB_CYC = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic raw_i,
    output logic sync_o,
    output logic level_o
);
    localparam int unsigned CNT_W = (DB_CYC < 2) ? 1 : $clog2(DB_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYC - 1);

    typedef struct packed {
        logic             meta;
        logic             sync;
        logic             level;
        logic [CNT_W-1:0] run;
    } flt_state_t;

    flt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_i;
        st_d.sync = st_q.meta;
        if (st_q.sync != st_q.level) begin
            if (st_q.run == CNT_LAST) begin
                st_d.level = st_q.sync;
                st_d.run   = '0;
            end else begin
                st_d.run   = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o  = st_q.sync;
    assign level_o = st_q.level;

endmodule

// File: rtl/kpt_ms_timer.sv
module kpt_ms_timer #(
    parameter int unsigned DIV   = 8,
    parameter int unsigned TMR_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic             tick_o,
    output logic [TMR_W-1:0] ms_o
);
    localparam int unsigned PS_W = (DIV < 2) ? 1 : $clog2(DIV);
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(DIV - 1);

    typedef struct packed {
        logic [PS_W-1:0]  presc;
        logic [TMR_W-1:0] ms;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.presc == PS_LAST);
        if (tick) begin
            st_d.presc = '0;
            st_d.ms    = st_q.ms + 1'b1;
        end else begin
            st_d.presc = st_q.presc + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick;
    assign ms_o   = st_q.ms;

endmodule

// File: rtl/kpt_bus_decode.sv
module kpt_bus_decode
    import kpt_pkg::*;
#(
    parameter int unsigned                 NUM_KEYS = 8,
    parameter int unsigned                 TMR_W    = 32,
    parameter logic [KPT_ADDR_W-1:0]       KEY_ADDR = KPT_KEY_ADDR,
    parameter logic [KPT_ADDR_W-1:0]       TMR_ADDR = KPT_TMR_ADDR
) (
    input  logic [KPT_ADDR_W-1:0] addr_i,
    input  logic                  rd_en_i,
    input  logic [NUM_KEYS-1:0]   keys_i,
    input  logic [TMR_W-1:0]      ms_i,
    output logic [KPT_DATA_W-1:0] rd_data_o
);
    kpt_sel_e sel;

    always_comb begin
        sel = SEL_NONE;
        if (rd_en_i) begin
            if (addr_i == KEY_ADDR) begin
                sel = SEL_KEYS;
            end else if (addr_i == TMR_ADDR) begin
                sel = SEL_TIMER;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        unique case (sel)
            SEL_KEYS:  rd_data_o = KPT_DATA_W'(keys_i);
            SEL_TIMER: rd_data_o = KPT_DATA_W'(ms_i);
            default:   rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/kpt_io_periph.sv
module kpt_io_periph
    import kpt_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned DEBOUNCE_MS = 10,
    parameter int unsigned NUM_KEYS    = 8,
    parameter int unsigned TMR_W       = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [KPT_ADDR_W-1:0] bus_addr_i,
    input  logic                  bus_rd_en_i,
    input  logic                  bus_wr_en_i,
    input  logic [KPT_DATA_W-1:0] bus_wr_data_i,
    output logic [KPT_DATA_W-1:0] bus_rd_data_o,
    input  logic [NUM_KEYS-1:0]   keys_raw_i
);
    localparam int unsigned DIV    = CLK_HZ / 1000;
    localparam int unsigned DB_CYC = DIV * DEBOUNCE_MS;

    logic [NUM_KEYS-1:0] key_sync;
    logic [NUM_KEYS-1:0] key_level;
    logic                ms_tick;
    logic [TMR_W-1:0]    ms_count;

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        kpt_key_filter #(
            .DB_CYC (DB_CYC)
        ) i_filter (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .raw_i   (keys_raw_i[k]),
            .sync_o  (key_sync[k]),
            .level_o (key_level[k])
        );
    end

    kpt_ms_timer #(
        .DIV   (DIV),
        .TMR_W (TMR_W)
    ) i_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (ms_tick),
        .ms_o   (ms_count)
    );

    kpt_bus_decode #(
        .NUM_KEYS (NUM_KEYS),
        .TMR_W    (TMR_W)
    ) i_decode (
        .addr_i    (bus_addr_i),
        .rd_en_i   (bus_rd_en_i),
        .keys_i    (key_level),
        .ms_i      (ms_count),
        .rd_data_o (bus_rd_data_o)
    );

endmodule

// File: rtl/kpt_io_checker.sv
module kpt_io_checker
    import kpt_pkg::*;
#(
    parameter int unsigned NUM_KEYS = 8,
    parameter int unsigned TMR_W    = 32
) (
    input logic                  clk_i,
    input logic                  rst_i,
    input logic [KPT_ADDR_W-1:0] bus_addr_i,
    input logic                  bus_rd_en_i,
    input logic                  bus_wr_en_i,
    input logic [KPT_DATA_W-1:0] bus_wr_data_i,
    input logic [KPT_DATA_W-1:0] bus_rd_data_o,
    input logic [NUM_KEYS-1:0]   key_sync,
    input logic [NUM_KEYS-1:0]   key_level,
    input logic                  ms_tick,
    input logic [TMR_W-1:0]      ms_count
);
    logic wr_hit;
    assign wr_hit = bus_wr_en_i && (bus_wr_data_i != '0 || bus_wr_data_i == '0)
                    && (bus_addr_i == KPT_KEY_ADDR || bus_addr_i == KPT_TMR_ADDR);

    // R7: no read request means zero on the data lines
    p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !bus_rd_en_i |-> (bus_rd_data_o == '0));

    // R1: upper bits of a keypad read are zero
    p_key_upper_zero_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_rd_en_i && bus_addr_i == KPT_KEY_ADDR)
        |-> (bus_rd_data_o[KPT_DATA_W-1:NUM_KEYS] == '0));

    // R9: a timer read returns the live count in the same cycle
    p_same_cycle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_rd_en_i && bus_addr_i == KPT_TMR_ADDR)
        |-> (bus_rd_data_o == KPT_DATA_W'(ms_count)));

    // R4: the count only moves on a tick and then by one
    p_step_one_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        ms_tick |=> (ms_count == $past(ms_count) + 1'b1));

    p_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !ms_tick |=> $stable(ms_count));

    // R3: a filtered bit only ever moves to the synchronized value
    p_level_follows_sync_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (key_level != $past(key_level)) |-> $past(rst_i) ||
        (((key_level ^ $past(key_level)) & (key_level ^ $past(key_sync))) == '0));

    // R8: a write cannot move the filtered key state unless the sync side disagrees
    p_write_no_effect_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_hit && (key_sync == key_level)) |=> $stable(key_level));

endmodule

bind kpt_io_periph kpt_io_checker #(
    .NUM_KEYS (NUM_KEYS),
    .TMR_W    (TMR_W)
) i_kpt_io_checker (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .bus_addr_i    (bus_addr_i),
    .bus_rd_en_i   (bus_rd_en_i),
    .bus_wr_en_i   (bus_wr_en_i),
    .bus_wr_data_i (bus_wr_data_i),
    .bus_rd_data_o (bus_rd_data_o),
    .key_sync      (key_sync),
    .key_level     (key_level),
    .ms_tick       (ms_tick),
    .ms_count      (ms_count)
);

// File: tb/test_kpt_io_periph.sv
module test_kpt_io_periph;

    localparam int unsigned CLK_PERIOD  = 10;
    localparam int unsigned CLK_HZ      = 8000;
    localparam int unsigned DEBOUNCE_MS = 2;
    localparam int unsigned TMR_W       = 8;
    localparam int unsigned MS_CYC      = CLK_HZ / 1000;
    localparam int unsigned FILT_CYC    = MS_CYC * DEBOUNCE_MS;
    localparam logic [31:0] A_KEY       = 32'hFFFF_0004;
    localparam logic [31:0] A_TMR       = 32'hFFFF_0008;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  keys = '0;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    string tag = "R6";

    always #(CLK_PERIOD/2) clk = ~clk;

    kpt_io_periph #(
        .CLK_HZ      (CLK_HZ),
        .DEBOUNCE_MS (DEBOUNCE_MS),
        .NUM_KEYS    (8),
        .TMR_W       (TMR_W)
    ) i_kpt_io_periph (
        .clk_i         (clk),
        .rst_i         (rst),
        .bus_addr_i    (addr),
        .bus_rd_en_i   (rd_en),
        .bus_wr_en_i   (wr_en),
        .bus_wr_data_i (wr_data),
        .bus_rd_data_o (rd_data),
        .keys_raw_i    (keys)
    );

    // Behavioural reference: a delay line for the two sampling stages,
    // a count of cycles each key has disagreed, and elapsed cycles.
    logic [7:0] pipe_a, pipe_b, held;
    int         disagree [8];
    int         elapsed;
    int         ms_ref;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            pipe_a  <= '0;
            pipe_b  <= '0;
            held    <= '0;
            elapsed <= 0;
            ms_ref  <= 0;
            for (int k = 0; k < 8; k++) disagree[k] <= 0;
        end else begin
            pipe_a <= keys;
            pipe_b <= pipe_a;
            for (int k = 0; k < 8; k++) begin
                if (pipe_b[k] != held[k]) begin
                    if (disagree[k] + 1 >= FILT_CYC) begin
                        held[k]     <= pipe_b[k];
                        disagree[k] <= 0;
                    end else begin
                        disagree[k] <= disagree[k] + 1;
                    end
                end else begin
                    disagree[k] <= 0;
                end
            end
            if (elapsed + 1 == MS_CYC) begin
                elapsed <= 0;
                ms_ref  <= (ms_ref + 1) % (1 << TMR_W);
            end else begin
                elapsed <= elapsed + 1;
            end
        end
    end

    function automatic logic [31:0] expect_data();
        if (!rd_en)          return '0;
        if (addr == A_KEY)   return {24'h0, held};
        if (addr == A_TMR)   return 32'(ms_ref);
        return '0;
    endfunction

    task automatic step(input logic [31:0] a, input logic rd, input logic wr,
                        input logic [7:0] k, input string t);
        logic [31:0] exp_v;
        @(negedge clk);
        addr  = a;
        rd_en = rd;
        wr_en = wr;
        wr_data = wr ? 32'hFFFF_FFFF : 32'h0;
        keys  = k;
        tag   = t;
        #1;
        exp_v = expect_data();
        vectors++;
        if (rd_data !== exp_v) begin
            miscompares++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, rd_data, exp_v);
        end
    endtask

    initial begin
        // R6: reads during reset
        for (int i = 0; i < 4; i++) step(i[0] ? A_KEY : A_TMR, 1'b1, 1'b0, 8'hFF, "R6");
        @(negedge clk); rst = 1'b0; keys = 8'h00;
        // R2 / R9: alternate timer and key reads right after reset
        for (int i = 0; i < 24; i++) step(i[0] ? A_KEY : A_TMR, 1'b1, 1'b0, 8'h00, "R9");
        // R1 / R3: press a pattern and hold it past the filter window
        for (int i = 0; i < 30; i++) step(A_KEY, 1'b1, 1'b0, 8'hA5, "R3");
        // R3: glitch on key 1 shorter than the window
        for (int i = 0; i < 5; i++)  step(A_KEY, 1'b1, 1'b0, 8'hA7, "R3");
        for (int i = 0; i < 30; i++) step(A_KEY, 1'b1, 1'b0, 8'hA5, "R3");
        // R1: another pattern, then release
        for (int i = 0; i < 30; i++) step(A_KEY, 1'b1, 1'b0, 8'h5A, "R1");
        for (int i = 0; i < 30; i++) step(A_KEY, 1'b1, 1'b0, 8'h00, "R1");
        for (int i = 0; i < 30; i++) step(A_KEY, 1'b1, 1'b0, 8'hFF, "R1");
        // R7: stray and unaligned addresses, and no read request
        for (int i = 0; i < 3; i++) step(32'hFFFF_0005, 1'b1, 1'b0, 8'hFF, "R7");
        for (int i = 0; i < 3; i++) step(32'hFFFF_000C, 1'b1, 1'b0, 8'hFF, "R7");
        for (int i = 0; i < 3; i++) step(32'hFFFF_0000, 1'b1, 1'b0, 8'hFF, "R7");
        for (int i = 0; i < 3; i++) step(32'h0000_0004, 1'b1, 1'b0, 8'hFF, "R7");
        for (int i = 0; i < 3; i++) step(32'hFFFF_0009, 1'b1, 1'b0, 8'hFF, "R7");
        for (int i = 0; i < 3; i++) step(A_KEY, 1'b0, 1'b0, 8'hFF, "R7");
        for (int i = 0; i < 3; i++) step(A_TMR, 1'b0, 1'b0, 8'hFF, "R7");
        // R8: write both registers, then read them back
        for (int i = 0; i < 20; i++) step(i[0] ? A_KEY : A_TMR, 1'b0, 1'b1, 8'hFF, "R8");
        for (int i = 0; i < 20; i++) step(i[0] ? A_KEY : A_TMR, 1'b1, 1'b1, 8'hFF, "R8");
        for (int i = 0; i < 6; i++)  step(i[0] ? A_KEY : A_TMR, 1'b1, 1'b0, 8'hFF, "R8");
        // R4 / R5: long timer run through the rollover
        for (int i = 0; i < 2200; i++) step(A_TMR, 1'b1, 1'b0, 8'h3C, i < 1200 ? "R4" : "R5");
        // R6: reset in mid-run, then resume
        @(negedge clk); rst = 1'b1;
        for (int i = 0; i < 3; i++) step(i[0] ? A_KEY : A_TMR, 1'b1, 1'b0, 8'h3C, "R6");
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 40; i++) step(i[0] ? A_KEY : A_TMR, 1'b1, 1'b0, 8'h3C, "R6");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        miscompares++;
        $display("FAIL watchdog actual=%0d cycles expected=<20000", cycles);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule